// File: doc/BRIEF.md
# Time-Measurement Core Register Bank

This block is the 32-bit memory-mapped register file that sits between a simple peek/poke bus and a time-to-digital measurement core. Software writes control flags, two delay fields, four pulser period words and two restart pulser words. The bank drives these straight to the core as level outputs. The core reports its reset and PPS-capture status and delivers pairs of 40-bit offset results. The bank keeps the latest pair and exposes it as four 32-bit words.

An offset pair must be read coherently. Reading the high word of the sample-side offset returns the live value and its valid flag. On the same edge it freezes the sample-side low word and both reference-side words. Those frozen words stay put until the next high-word read, even when the core delivers newer results in between. A two-state machine tracks whether an unread result is pending. In `RES_STALE` nothing new has arrived since the last snapshot. In `RES_FRESH` a newer result is waiting. The transition *deliver* (result strobe) moves to `RES_FRESH`. The transition *consume* (high-word read with no strobe in the same cycle) returns to `RES_STALE`. The transition *wipe* (master reset bit 0) forces `RES_STALE`.

The bank also holds a constant signature, a revision word and an oldest-compatible revision word, plus a scratch register. It has two reset controls. One is a self-clearing wipe that zeroes every register. The other is a level-held core reset that stays asserted until software clears it.

Top module: `tmc_reg_bank`

## Requirements
- R1: Reads of 0x100, 0x104 and 0x108 return the signature 0x73796E63, the revision parameter and the oldest-compatible parameter respectively.
- R2: The scratch word at 0x10C stores all 32 written bits and reads them back.
- R3: A write to 0x000 replaces the control flags: bit 13 core reset request, bit 12 PPS crossing enable, bit 8 PPS capture clear, bit 5 re-run enable, bit 4 core enable. Each drives its output from the next cycle. The other flag bits read back as 0.
- R4: Bits 19:16 of a control write load the output PPS delay only if bit 20 is set in that write. Bits 27:24 load the pulser enable delay only if bit 28 is set. Both fields read back at those positions.
- R5: Period words at 0x020, 0x024, 0x028 and 0x02C keep bits 30:0. The restart period word at 0x040 keeps bits 23:0 and the restart high word at 0x044 keeps bits 22:0. Each drives its output port.
- R6: The status word at 0x008 reads the core-in-reset input at bit 0 and the PPS-captured input at bit 4.
- R7: Bit 8 of the sample-side high word (0x018) reads 1 once the core strobes a result. A high-word read clears it unless a new strobe arrives in the same cycle. It reads 0 after reset.
- R8: Bits 7:0 of 0x018 are offset bits 39:32. A read of 0x018 freezes 0x014 (sample low), 0x010 (reference high, with the valid flag at bit 8) and 0x00C (reference low) from the same result. They are not changed by later strobes until 0x018 is read again.
- R9: Writing 1 to bit 0 of 0x030 zeroes every writable register, the stored results and the snapshot, and clears the valid flag. Bit 0 reads back as 0.
- R10: Bit 4 of 0x030 drives the core hard reset output and reads back at bit 4. It holds its value until 0x030 is written again.
- R11: Reads of unmapped addresses return 0. Writes to read-only addresses change nothing.
- R12: Read data is registered: it holds the addressed word in the cycle after rd_en and is 0 in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| core_in_reset | input | 1 | Core reports it is in reset |
| pps_captured | input | 1 | Core reports a PPS was captured |
| res_stb | input | 1 | New offset pair available |
| sp_off | input | 40 | Sample-side offset |
| rp_off | input | 40 | Reference-side offset |
| core_rst_req | output | 1 | Core reset request flag |
| pps_clear | output | 1 | PPS capture clear flag |
| rerun_en | output | 1 | Re-run enable flag |
| core_en | output | 1 | Core enable flag |
| pps_xing_en | output | 1 | PPS crossing enable flag |
| pps_out_dly | output | 4 | Output PPS delay |
| pulser_dly | output | 4 | Pulser enable delay |
| ref_pulse_word | output | 31 | Reference pulser period word |
| smp_pulse_word | output | 31 | Sample pulser period word |
| ref_tick_word | output | 31 | Reference tick pulser word |
| smp_tick_word | output | 31 | Sample tick pulser word |
| restart_period | output | 24 | Restart pulser period |
| restart_high | output | 23 | Restart pulser high time |
| core_hard_rst | output | 1 | Level-held core reset |

## Verification
Every read result is due exactly one cycle after the edge that samples rd_en. The bench monitor records rd_en at each rising edge and compares rd_data a quarter period later against the head of the expected queue. Control, delay, period and reset outputs change on the edge that samples the write. The bench drives writes from a falling edge and inspects those outputs at the following falling edge. A snapshot is taken on the same edge as its high-word read, so the frozen words are checked after a further result strobe has gone through.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
    localparam logic [11:0] ADR_CTRL    = 12'h000;
    localparam logic [11:0] ADR_STAT    = 12'h008;
    localparam logic [11:0] ADR_RP_LO   = 12'h00C;
    localparam logic [11:0] ADR_RP_HI   = 12'h010;
    localparam logic [11:0] ADR_SP_LO   = 12'h014;
    localparam logic [11:0] ADR_SP_HI   = 12'h018;
    localparam logic [11:0] ADR_PRD0    = 12'h020;
    localparam logic [11:0] ADR_MRST    = 12'h030;
    localparam logic [11:0] ADR_RS_PRD  = 12'h040;
    localparam logic [11:0] ADR_RS_HI   = 12'h044;
    localparam logic [11:0] ADR_SIG     = 12'h100;
    localparam logic [11:0] ADR_REV     = 12'h104;
    localparam logic [11:0] ADR_COMPAT  = 12'h108;
    localparam logic [11:0] ADR_SCRATCH = 12'h10C;

    localparam int B_CORE_RST = 13;
    localparam int B_XING     = 12;
    localparam int B_PPS_CLR  = 8;
    localparam int B_RERUN    = 5;
    localparam int B_CORE_EN  = 4;
    localparam int B_OUT_DLY  = 16;
    localparam int B_OUT_UPD  = 20;
    localparam int B_PUL_DLY  = 24;
    localparam int B_PUL_UPD  = 28;
    localparam int B_WIPE     = 0;
    localparam int B_HARD_RST = 4;

    localparam logic [31:0] SIG_WORD = 32'h7379_6E63;

    typedef enum logic {
        RES_STALE = 1'b0,
        RES_FRESH = 1'b1
    } res_state_t;
endpackage

// File: rtl/tmc_cfg_regs.sv
module tmc_cfg_regs
    import tmc_pkg::*;
#(
    parameter int AW       = 12,
    parameter int DLY_W    = 4,
    parameter int NPRD     = 4,
    parameter int PRD_W    = 31,
    parameter int RS_PRD_W = 24,
    parameter int RS_HI_W  = 23
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [AW-1:0]         addr,
    input  logic [31:0]           wdata,
    output logic                  wipe,
    output logic [31:0]           flags,
    output logic [DLY_W-1:0]      out_dly,
    output logic [DLY_W-1:0]      pul_dly,
    output logic [NPRD*PRD_W-1:0] prd_words,
    output logic [RS_PRD_W-1:0]   rs_prd,
    output logic [RS_HI_W-1:0]    rs_hi,
    output logic                  hard_rst,
    output logic [31:0]           scratch
);
    localparam logic [31:0] FLAG_MASK = (32'd1 << B_CORE_RST) | (32'd1 << B_XING) |
                                        (32'd1 << B_PPS_CLR) | (32'd1 << B_RERUN) |
                                        (32'd1 << B_CORE_EN);

    logic wr_ctrl, wr_mrst, wr_scr, wr_rsp, wr_rsh;

    always_comb begin
        wr_ctrl = wr_en && (addr == AW'(ADR_CTRL));
        wr_mrst = wr_en && (addr == AW'(ADR_MRST));
        wr_scr  = wr_en && (addr == AW'(ADR_SCRATCH));
        wr_rsp  = wr_en && (addr == AW'(ADR_RS_PRD));
        wr_rsh  = wr_en && (addr == AW'(ADR_RS_HI));
        wipe    = wr_mrst && wdata[B_WIPE];
    end

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            flags    <= '0;
            out_dly  <= '0;
            pul_dly  <= '0;
            hard_rst <= 1'b0;
            scratch  <= '0;
            rs_prd   <= '0;
            rs_hi    <= '0;
        end else begin
            if (wr_ctrl) begin
                flags <= wdata & FLAG_MASK;
                if (wdata[B_OUT_UPD]) out_dly <= wdata[B_OUT_DLY +: DLY_W];
                if (wdata[B_PUL_UPD]) pul_dly <= wdata[B_PUL_DLY +: DLY_W];
            end
            if (wr_mrst) hard_rst <= wdata[B_HARD_RST];
            if (wr_scr)  scratch  <= wdata;
            if (wr_rsp)  rs_prd   <= wdata[RS_PRD_W-1:0];
            if (wr_rsh)  rs_hi    <= wdata[RS_HI_W-1:0];
        end
    end

    for (genvar i = 0; i < NPRD; i++) begin : g_prd
        localparam logic [AW-1:0] MY_ADR = AW'(ADR_PRD0) + AW'(4 * i);
        always_ff @(posedge clk) begin
            if (rst || wipe)
                prd_words[i*PRD_W +: PRD_W] <= '0;
            else if (wr_en && (addr == MY_ADR))
                prd_words[i*PRD_W +: PRD_W] <= wdata[PRD_W-1:0];
        end
    end
endmodule

// File: rtl/tmc_result_snap.sv
module tmc_result_snap
    import tmc_pkg::*;
#(
    parameter int OFF_W = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wipe,
    input  logic             res_stb,
    input  logic [OFF_W-1:0] sp_in,
    input  logic [OFF_W-1:0] rp_in,
    input  logic             snap_rd,
    output logic             fresh,
    output logic [OFF_W-1:0] live_sp,
    output logic [OFF_W-1:0] snap_sp,
    output logic [OFF_W-1:0] snap_rp,
    output logic             snap_vld
);
    res_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst || wipe) state_q <= RES_STALE;
        else             state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RES_STALE: if (res_stb) state_d = RES_FRESH;
            RES_FRESH: if (snap_rd && !res_stb) state_d = RES_STALE;
            default:   state_d = RES_STALE;
        endcase
    end

    assign fresh = (state_q == RES_FRESH);

    logic [OFF_W-1:0] live_rp;

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            live_sp  <= '0;
            live_rp  <= '0;
            snap_sp  <= '0;
            snap_rp  <= '0;
            snap_vld <= 1'b0;
        end else begin
            if (res_stb) begin
                live_sp <= sp_in;
                live_rp <= rp_in;
            end
            if (snap_rd) begin
                snap_sp  <= live_sp;
                snap_rp  <= live_rp;
                snap_vld <= fresh;
            end
        end
    end
endmodule

// File: rtl/tmc_reg_bank.sv
module tmc_reg_bank
    import tmc_pkg::*;
#(
    parameter int          AW        = 12,
    parameter int          OFF_W     = 40,
    parameter int          DLY_W     = 4,
    parameter int          PRD_W     = 31,
    parameter int          RS_PRD_W  = 24,
    parameter int          RS_HI_W   = 23,
    parameter logic [31:0] REV_WORD  = 32'h2401_0112,
    parameter logic [31:0] COMP_WORD = 32'h2306_0111
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [AW-1:0]       addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rd_data,
    input  logic                core_in_reset,
    input  logic                pps_captured,
    input  logic                res_stb,
    input  logic [OFF_W-1:0]    sp_off,
    input  logic [OFF_W-1:0]    rp_off,
    output logic                core_rst_req,
    output logic                pps_clear,
    output logic                rerun_en,
    output logic                core_en,
    output logic                pps_xing_en,
    output logic [DLY_W-1:0]    pps_out_dly,
    output logic [DLY_W-1:0]    pulser_dly,
    output logic [PRD_W-1:0]    ref_pulse_word,
    output logic [PRD_W-1:0]    smp_pulse_word,
    output logic [PRD_W-1:0]    ref_tick_word,
    output logic [PRD_W-1:0]    smp_tick_word,
    output logic [RS_PRD_W-1:0] restart_period,
    output logic [RS_HI_W-1:0]  restart_high,
    output logic                core_hard_rst
);
    localparam int NPRD  = 4;
    localparam int HI_W  = OFF_W - 32;

    logic                  wipe;
    logic [31:0]           flags;
    logic [NPRD*PRD_W-1:0] prd_words;
    logic [31:0]           scratch;
    logic                  fresh, snap_vld, snap_rd;
    logic [OFF_W-1:0]      live_sp, snap_sp, snap_rp;
    logic [31:0]           rd_mux;

    tmc_cfg_regs #(
        .AW(AW), .DLY_W(DLY_W), .NPRD(NPRD), .PRD_W(PRD_W),
        .RS_PRD_W(RS_PRD_W), .RS_HI_W(RS_HI_W)
    ) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .wipe(wipe), .flags(flags), .out_dly(pps_out_dly), .pul_dly(pulser_dly),
        .prd_words(prd_words), .rs_prd(restart_period), .rs_hi(restart_high),
        .hard_rst(core_hard_rst), .scratch(scratch)
    );

    assign snap_rd = rd_en && (addr == AW'(ADR_SP_HI));

    tmc_result_snap #(.OFF_W(OFF_W)) u_snap (
        .clk(clk), .rst(rst), .wipe(wipe), .res_stb(res_stb),
        .sp_in(sp_off), .rp_in(rp_off), .snap_rd(snap_rd),
        .fresh(fresh), .live_sp(live_sp), .snap_sp(snap_sp),
        .snap_rp(snap_rp), .snap_vld(snap_vld)
    );

    assign core_rst_req   = flags[B_CORE_RST];
    assign pps_xing_en    = flags[B_XING];
    assign pps_clear      = flags[B_PPS_CLR];
    assign rerun_en       = flags[B_RERUN];
    assign core_en        = flags[B_CORE_EN];
    assign ref_pulse_word = prd_words[0*PRD_W +: PRD_W];
    assign smp_pulse_word = prd_words[1*PRD_W +: PRD_W];
    assign ref_tick_word  = prd_words[2*PRD_W +: PRD_W];
    assign smp_tick_word  = prd_words[3*PRD_W +: PRD_W];

    always_comb begin
        rd_mux = '0;
        case (addr)
            AW'(ADR_CTRL):    rd_mux = flags
                                     | (32'(pps_out_dly) << B_OUT_DLY)
                                     | (32'(pulser_dly)  << B_PUL_DLY);
            AW'(ADR_STAT):    rd_mux = 32'(core_in_reset) | (32'(pps_captured) << 4);
            AW'(ADR_RP_LO):   rd_mux = snap_rp[31:0];
            AW'(ADR_RP_HI):   rd_mux = 32'(snap_rp[OFF_W-1:32]) | (32'(snap_vld) << HI_W);
            AW'(ADR_SP_LO):   rd_mux = snap_sp[31:0];
            AW'(ADR_SP_HI):   rd_mux = 32'(live_sp[OFF_W-1:32]) | (32'(fresh) << HI_W);
            AW'(ADR_MRST):    rd_mux = 32'(core_hard_rst) << B_HARD_RST;
            AW'(ADR_RS_PRD):  rd_mux = 32'(restart_period);
            AW'(ADR_RS_HI):   rd_mux = 32'(restart_high);
            AW'(ADR_SIG):     rd_mux = SIG_WORD;
            AW'(ADR_REV):     rd_mux = REV_WORD;
            AW'(ADR_COMPAT):  rd_mux = COMP_WORD;
            AW'(ADR_SCRATCH): rd_mux = scratch;
            default: begin
                for (int i = 0; i < NPRD; i++)
                    if (addr == AW'(ADR_PRD0) + AW'(4 * i))
                        rd_mux = 32'(prd_words[i*PRD_W +: PRD_W]);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
        else            rd_data <= '0;
    end
endmodule

// File: rtl/tmc_reg_bank_chk.sv
module tmc_reg_bank_chk
    import tmc_pkg::*;
#(
    parameter int AW    = 12,
    parameter int DLY_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             rd_en,
    input logic [AW-1:0]    addr,
    input logic [31:0]      wdata,
    input logic [31:0]      rd_data,
    input logic             core_en,
    input logic             core_hard_rst,
    input logic [DLY_W-1:0] pps_out_dly
);
    assert_ctrl_load_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == AW'(ADR_CTRL)) |=> (core_en == $past(wdata[B_CORE_EN])));

    assert_dly_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == AW'(ADR_CTRL) && wdata[B_OUT_UPD]) && !(wr_en && addr == AW'(ADR_MRST))
        |=> $stable(pps_out_dly));

    assert_wipe_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == AW'(ADR_MRST) && wdata[B_WIPE])
        |=> (!core_hard_rst && !core_en && pps_out_dly == '0));

    assert_hard_rst_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == AW'(ADR_MRST)) |=> $stable(core_hard_rst));

    assert_signature_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == AW'(ADR_SIG)) |=> (rd_data == SIG_WORD));

    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == AW'(12'h004)) |=> (rd_data == 32'd0));

    assert_idle_zero_R12: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rd_data == 32'd0));
endmodule

bind tmc_reg_bank tmc_reg_bank_chk #(.AW(AW), .DLY_W(DLY_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .core_en(core_en),
    .core_hard_rst(core_hard_rst), .pps_out_dly(pps_out_dly)
);

// File: tb/tb_tmc_reg_bank.sv
module tb_tmc_reg_bank;
    localparam int CLK_P = 10;

    logic        clk = 0;
    logic        rst = 1;
    logic        wr_en = 0, rd_en = 0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic        core_in_reset = 0, pps_captured = 0, res_stb = 0;
    logic [39:0] sp_off = '0, rp_off = '0;
    logic        core_rst_req, pps_clear, rerun_en, core_en, pps_xing_en;
    logic [3:0]  pps_out_dly, pulser_dly;
    logic [30:0] ref_pulse_word, smp_pulse_word, ref_tick_word, smp_tick_word;
    logic [23:0] restart_period;
    logic [22:0] restart_high;
    logic        core_hard_rst;

    int n_vec = 0, n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_P/2) clk = ~clk;

    tmc_reg_bank dut (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
        @(negedge clk); rd_en = 1; addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); rd_en = 0;
    endtask

    task automatic deliver(logic [39:0] sp, logic [39:0] rp);
        @(negedge clk); sp_off = sp; rp_off = rp; res_stb = 1;
        @(negedge clk); res_stb = 0;
    endtask

    initial begin : monitor
        forever begin
            logic was;
            @(posedge clk);
            was = rd_en;
            #(CLK_P/4);
            if (was) begin
                if (exp_q.size() == 0) chk("scoreboard underflow", 32'd1, 32'd0);
                else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin : watchdog
        #(CLK_P * 100000);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R3 reset core_en", 32'(core_en), 0);
        chk("R10 reset hard_rst", 32'(core_hard_rst), 0);
        rd(12'h018, 32'h0, "R7 valid clear after reset");

        rd(12'h100, 32'h7379_6E63, "R1 signature");
        rd(12'h104, 32'h2401_0112, "R1 revision");
        rd(12'h108, 32'h2306_0111, "R1 compat");

        wr(12'h10C, 32'hDEAD_BEEF);
        rd(12'h10C, 32'hDEAD_BEEF, "R2 scratch");
        wr(12'h100, 32'h0);
        rd(12'h100, 32'h7379_6E63, "R11 RO write ignored");
        rd(12'h004, 32'h0, "R11 unmapped");
        rd(12'h200, 32'h0, "R11 unmapped high");

        core_in_reset = 1;
        rd(12'h008, 32'h01, "R6 status in reset");
        core_in_reset = 0; pps_captured = 1;
        rd(12'h008, 32'h10, "R6 status pps");

        wr(12'h000, 32'h0000_2121);
        chk("R3 core_rst_req", 32'(core_rst_req), 1);
        chk("R3 pps_clear", 32'(pps_clear), 1);
        chk("R3 rerun_en", 32'(rerun_en), 1);
        chk("R3 core_en", 32'(core_en), 0);
        rd(12'h000, 32'h0000_2120, "R3 ctrl readback");
        wr(12'h000, 32'h0000_1010);
        chk("R3 core_en set", 32'(core_en), 1);
        chk("R3 xing set", 32'(pps_xing_en), 1);
        chk("R3 rst_req clear", 32'(core_rst_req), 0);

        wr(12'h000, 32'h0005_0000);
        chk("R4 no update", 32'(pps_out_dly), 0);
        wr(12'h000, 32'h0015_0000);
        chk("R4 out dly load", 32'(pps_out_dly), 5);
        wr(12'h000, 32'h1700_0000);
        chk("R4 pulser dly load", 32'(pulser_dly), 7);
        chk("R4 out dly held", 32'(pps_out_dly), 5);
        rd(12'h000, 32'h0705_0000, "R4 ctrl readback");

        wr(12'h020, 32'hFFFF_FFFF);
        rd(12'h020, 32'h7FFF_FFFF, "R5 period mask");
        wr(12'h02C, 32'h01F4_03E8);
        rd(12'h02C, 32'h01F4_03E8, "R5 tick word");
        chk("R5 smp_tick port", 32'(smp_tick_word), 32'h01F4_03E8);
        chk("R5 ref_pulse port", 32'(ref_pulse_word), 32'h7FFF_FFFF);
        wr(12'h040, 32'hFFFF_FFFF);
        rd(12'h040, 32'h00FF_FFFF, "R5 restart period");
        wr(12'h044, 32'hFFFF_FFFF);
        rd(12'h044, 32'h007F_FFFF, "R5 restart high");

        deliver(40'h12_3456_789A, 40'h0A_BCDE_F012);
        rd(12'h018, 32'h0000_0112, "R7 valid set and R8 hi byte");
        deliver(40'h34_1111_2222, 40'h56_3333_4444);
        rd(12'h014, 32'h3456_789A, "R8 frozen sp low");
        rd(12'h010, 32'h0000_010A, "R8 frozen rp high");
        rd(12'h00C, 32'hBCDE_F012, "R8 frozen rp low");
        rd(12'h018, 32'h0000_0134, "R7 new result valid");
        rd(12'h018, 32'h0000_0034, "R7 valid cleared");
        rd(12'h014, 32'h1111_2222, "R8 new sp low");
        rd(12'h010, 32'h0000_0056, "R8 rp high stale flag");
        rd(12'h00C, 32'h3333_4444, "R8 new rp low");

        wr(12'h030, 32'h0000_0010);
        chk("R10 hard rst set", 32'(core_hard_rst), 1);
        wr(12'h000, 32'h0000_0010);
        chk("R10 hard rst held", 32'(core_hard_rst), 1);
        rd(12'h030, 32'h0000_0010, "R10 readback");
        wr(12'h030, 32'h0000_0000);
        chk("R10 hard rst cleared", 32'(core_hard_rst), 0);

        wr(12'h10C, 32'h1234_5678);
        wr(12'h000, 32'h0015_1010);
        deliver(40'h77_0000_0001, 40'h66_0000_0002);
        wr(12'h030, 32'h0000_0011);
        chk("R9 core_en wiped", 32'(core_en), 0);
        chk("R9 hard rst wiped", 32'(core_hard_rst), 0);
        chk("R9 dly wiped", 32'(pps_out_dly), 0);
        chk("R9 period port wiped", 32'(ref_pulse_word), 0);
        rd(12'h10C, 32'h0, "R9 scratch wiped");
        rd(12'h030, 32'h0, "R9 mrst reads zero");
        rd(12'h018, 32'h0, "R9 result wiped");
        rd(12'h00C, 32'h0, "R9 snapshot wiped");

        repeat (2) @(negedge clk);
        chk("R12 idle rd_data", rd_data, 32'h0);
        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule